// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Overrides

An eight-pin general-purpose I/O port driven from a small register bus. Software sets a per-pin direction mask, writes an output latch, and reads either the latch contents or the synchronized pin levels through separate addresses. Each pin presents an input, an output value and an output-enable to the pad ring.

Two peripherals can take pins away from software. An auxiliary PWM engine, when running in dual or quad mode, claims the upper three pins and drives them directly. An external control bit can request parallel-slave-port operation, in which case software drive is withdrawn from all pins and the synchronized pin bus is handed to the external port logic. The PWM has priority: dual or quad mode vetoes the parallel-port request.

Register map (2-bit address): 0 = pin levels (read) / latch (write), 1 = latch, 2 = direction, 3 = reserved. PWM mode encoding on `pwm_mode_i`: 0 = off, 1 = single, 2 = dual, 3 = quad.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the latch reads 0x00, and every output-enable is low.
- R2: A pin whose direction bit is 0 has its output-enable high and drives its latch bit; a direction bit of 1 leaves the output-enable low.
- R3: Direction bits act per pin; writing 0xCF to address 2 gives output-enables 0x30 (bits 5:4 outputs, the rest inputs).
- R4: A read of address 1 returns the latch value, never the pin level.
- R5: A read of address 0 returns the pin inputs through a two-flop synchronizer: a level applied before rising edge n is readable after edge n+1 and not after edge n alone.
- R6: A write to address 0 updates the latch exactly as a write to address 1 does.
- R7: In dual PWM mode pin 5 is driven by `pwm_val_i[0]` with output-enable forced high; in quad mode pins 5, 6, 7 are driven by `pwm_val_i[0]`, `[1]`, `[2]` likewise, regardless of direction and latch bits.
- R8: When `psp_req_i` is high and PWM mode is off or single, `psp_active_o` is high and all output-enables are low; `psp_bus_o` carries the synchronized pin levels.
- R9: In dual or quad PWM mode `psp_active_o` stays low even while `psp_req_i` is high.
- R10: Address 3 reads 0x00 and writes to it change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output-enables (1 = drive) |
| pwm_mode_i | input | 2 | PWM output mode |
| pwm_val_i | input | 3 | PWM output levels for the three shared pins |
| psp_req_i | input | 1 | Parallel-port mode request |
| psp_active_o | output | 1 | Parallel-port mode granted |
| psp_bus_o | output | 8 | Synchronized pin bus for parallel-port logic |

## Verification
The direction logic is driven with the mixed mask 0xCF, with all-outputs, and with a walking zero, which separates a per-pin decode from one that shares bits. Latch and pin reads are taken with pin levels that differ from the latch, so a swapped read path shows, and the pin change is sampled one and two edges later to pin down the synchronizer depth. PWM and parallel-port requests are applied in every PWM mode, with direction both all-input and all-output, to tell ownership priority from a plain OR of enables.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PWM_OFF    = 2'd0,
    PWM_SINGLE = 2'd1,
    PWM_DUAL   = 2'd2,
    PWM_QUAD   = 2'd3
  } pwm_mode_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  lat_o,
  output logic [WIDTH-1:0]  rdata_o
);
  reg_addr_e        addr;
  logic [WIDTH-1:0] dir_q, lat_q;

  assign addr = reg_addr_e'(addr_i);

  // 1 = input; all pins come up as inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (we_i) begin
      unique case (addr)
        REG_PORT, REG_LAT: lat_q <= wdata_i;
        REG_DIR:           dir_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      REG_PORT: rdata_o = pin_sync_i;
      REG_LAT:  rdata_o = lat_q;
      REG_DIR:  rdata_o = dir_q;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_port_arb.sv
module gpio_port_arb
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned PWM_BASE = 5,
  parameter int unsigned PWM_N    = 3
) (
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] lat_i,
  input  logic [1:0]       pwm_mode_i,
  input  logic [PWM_N-1:0] pwm_val_i,
  input  logic             psp_req_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic             psp_active_o
);
  localparam int unsigned PWM_TOP = PWM_BASE + PWM_N;

  pwm_mode_e        mode;
  logic             pwm_multi;
  logic [PWM_N-1:0] own;
  logic [WIDTH-1:0] gp_oe;

  assign mode      = pwm_mode_e'(pwm_mode_i);
  assign pwm_multi = (mode == PWM_DUAL) || (mode == PWM_QUAD);

  // dual claims the first shared pin, quad claims all of them
  for (genvar c = 0; c < PWM_N; c++) begin : g_own
    if (c == 0) begin : g_c0
      assign own[c] = pwm_multi;
    end else begin : g_cn
      assign own[c] = (mode == PWM_QUAD);
    end
  end

  // PWM multi-output mode vetoes parallel-port mode
  assign psp_active_o = psp_req_i && !pwm_multi;
  assign gp_oe        = psp_active_o ? '0 : ~dir_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= PWM_BASE && i < PWM_TOP) begin : g_shared
      assign pin_o[i]    = own[i-PWM_BASE] ? pwm_val_i[i-PWM_BASE] : lat_i[i];
      assign pin_oe_o[i] = own[i-PWM_BASE] | gp_oe[i];
    end else begin : g_plain
      assign pin_o[i]    = lat_i[i];
      assign pin_oe_o[i] = gp_oe[i];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned PWM_BASE = 5,
  parameter int unsigned PWM_N    = 3,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  input  logic [1:0]        pwm_mode_i,
  input  logic [PWM_N-1:0]  pwm_val_i,
  input  logic              psp_req_i,
  output logic              psp_active_o,
  output logic [WIDTH-1:0]  psp_bus_o
);
  logic [WIDTH-1:0] pin_sync, dir_q, lat_q;

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .dir_o     (dir_q),
    .lat_o     (lat_q),
    .rdata_o   (rdata_o)
  );

  gpio_port_arb #(.WIDTH(WIDTH), .PWM_BASE(PWM_BASE), .PWM_N(PWM_N)) u_arb (
    .dir_i       (dir_q),
    .lat_i       (lat_q),
    .pwm_mode_i  (pwm_mode_i),
    .pwm_val_i   (pwm_val_i),
    .psp_req_i   (psp_req_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o),
    .psp_active_o(psp_active_o)
  );

  assign psp_bus_o = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned PWM_BASE = 5,
  parameter int unsigned PWM_N    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       addr_i,
  input logic             we_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [1:0]       pwm_mode_i,
  input logic             psp_req_i,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic             psp_active_o,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] lat_q
);
  // R4 R6
  latch_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i[1]) |=> (lat_q == $past(wdata_i)));

  // R10
  rsvd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd3) |=> ($stable(lat_q) && $stable(dir_q)));

  // R7
  pwm_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode_i == 2'd3) |-> (&pin_oe_o[PWM_BASE +: PWM_N]));

  // R8
  psp_drive_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psp_active_o |-> (pin_oe_o == '0));

  // R9
  psp_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode_i[1] && psp_req_i) |-> !psp_active_o);

  // R2
  gp_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psp_req_i && !pwm_mode_i[1]) |-> (pin_oe_o == ~dir_q));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .PWM_BASE(PWM_BASE), .PWM_N(PWM_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .pwm_mode_i  (pwm_mode_i),
  .psp_req_i   (psp_req_i),
  .pin_oe_o    (pin_oe_o),
  .psp_active_o(psp_active_o),
  .dir_q       (dir_q),
  .lat_q       (lat_q)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic [1:0] pwm_mode = '0;
  logic [2:0] pwm_val = '0;
  logic       psp_req = 1'b0;
  logic       psp_active;
  logic [7:0] psp_bus;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_port u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .pwm_mode_i(pwm_mode), .pwm_val_i(pwm_val), .psp_req_i(psp_req),
    .psp_active_o(psp_active), .psp_bus_o(psp_bus)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd2, v); check("R1 dir", v, 8'hFF);
    rd(2'd1, v); check("R1 latch", v, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
  endtask

  task automatic t_dir_mask();
    logic [7:0] v;
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'hCF);
    #1;
    check("R3 oe for 0xCF", pin_oe, 8'h30);
    check("R2 driven bits", pin_out & 8'h30, 8'h20);
    rd(2'd2, v); check("R3 dir readback", v, 8'hCF);
    wr(2'd2, 8'h00);
    #1;
    check("R2 all outputs oe", pin_oe, 8'hFF);
    check("R2 all outputs value", pin_out, 8'hA5);
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, ~(8'h01 << i));
      #1 check("R3 walking zero", pin_oe, 8'h01 << i);
    end
    wr(2'd2, 8'hFF);
    #1 check("R2 all inputs", pin_oe, 8'h00);
  endtask

  task automatic t_latch_vs_pin();
    logic [7:0] v;
    @(negedge clk) pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R4 latch read", v, 8'hA5);
    rd(2'd0, v); check("R5 pin read", v, 8'h3C);
    // latency: apply at negedge, check after one and two rising edges
    @(negedge clk);
    addr = 2'd0; pin_in = 8'h81;
    @(negedge clk);
    #1 check("R5 one edge old", rdata, 8'h3C);
    @(negedge clk);
    #1 check("R5 two edges new", rdata, 8'h81);
  endtask

  task automatic t_port_write();
    logic [7:0] v;
    wr(2'd0, 8'h5A);
    rd(2'd1, v); check("R6 port write to latch", v, 8'h5A);
    rd(2'd0, v); check("R6 port read still pins", v, 8'h81);
  endtask

  task automatic t_pwm();
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h00);
    @(negedge clk);
    pwm_mode = 2'd2; pwm_val = 3'b111;
    #1 check("R7 dual oe", pin_oe, 8'h20);
    check("R7 dual value", pin_out & 8'h20, 8'h20);
    pwm_mode = 2'd3; pwm_val = 3'b101;
    #1 check("R7 quad oe", pin_oe, 8'hE0);
    check("R7 quad value", pin_out & 8'hE0, 8'hA0);
    wr(2'd2, 8'h00);
    @(negedge clk);
    pwm_val = 3'b010;
    #1 check("R7 quad over latch", pin_out, 8'h40);
    check("R7 quad oe all out", pin_oe, 8'hFF);
    pwm_mode = 2'd1;
    #1 check("R7 single no takeover", pin_out, 8'h00);
    pwm_mode = 2'd0;
  endtask

  task automatic t_psp();
    @(negedge clk);
    psp_req = 1'b1; pwm_mode = 2'd0;
    #1 check("R8 psp active", {7'd0, psp_active}, 8'h01);
    check("R8 psp drive off", pin_oe, 8'h00);
    check("R8 psp bus", psp_bus, 8'h81);
    pwm_mode = 2'd1;
    #1 check("R8 psp with single", {7'd0, psp_active}, 8'h01);
    pwm_mode = 2'd2;
    #1 check("R9 dual veto", {7'd0, psp_active}, 8'h00);
    check("R9 dual gp drive back", pin_oe, 8'hFF);
    pwm_mode = 2'd3;
    #1 check("R9 quad veto", {7'd0, psp_active}, 8'h00);
    @(negedge clk);
    psp_req = 1'b0; pwm_mode = 2'd0;
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hC3);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R10 reserved read", v, 8'h00);
    rd(2'd1, v); check("R10 latch kept", v, 8'h3C);
    rd(2'd2, v); check("R10 dir kept", v, 8'hC3);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_mask();
    t_latch_vs_pin();
    t_port_write();
    t_pwm();
    t_psp();
    t_reserved();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule